// File: doc/BRIEF.md
# Stereo Audio Sample FIFO Controller

This block sits between a host register bus and the serial side of an audio port. It holds two queues of 32-bit samples. The receive queue is filled by the audio side and drained by the host. The transmit queue is filled by the host and drained by the audio side. Stereo data is carried interleaved, with a left sample followed by its right sample, so each host access moves exactly one sample.

Each queue has a programmable trigger level. The receive request is active while enough samples are waiting. The transmit request is active while the transmit queue has run low. These conditions drive DMA request lines directly. They also drive pending flags that feed a maskable interrupt. A pending flag sets when its condition becomes true. The host can clear it by writing a 1, and it also drops by itself once the condition stops holding. A receive overrun sets a separate flag that stays set until the host clears it. Either queue can be emptied with a flush bit that never reads back as 1.

Top module: `afq_ctrl`

## Requirements
- R1: After reset, CTRL (offset 0x00) reads 0x000400F0, LVL (offset 0x14) reads 0, the interrupt is low and the hub enable output is low.
- R2: Each host read of RXD (offset 0x0C) returns the oldest receive sample and removes it, so samples come out in push order (left, right, left, right). A read of an empty queue returns 0.
- R3: The receive DMA request is high exactly while receive occupancy is at least the CTRL[9:4] field plus one.
- R4: Status bit 0 sets one cycle after the R3 condition turns true. Writing 1 to bit 0 of STAT (offset 0x04) clears it, and it stays clear while the condition keeps holding. It clears by itself one cycle after the condition turns false.
- R5: A push into a full receive queue (64 entries) is dropped, and the stored samples are unchanged. It sets status bit 1, which only a write of 1 to STAT bit 1 clears.
- R6: The transmit DMA request is high exactly while transmit occupancy is at most the CTRL[18:12] field. Status bit 2 follows this condition with the set, one-write-clear and self-clear rules of R4.
- R7: Writing CTRL with bit 24 set empties the receive queue, and with bit 25 set empties the transmit queue. Both bits always read back as 0.
- R8: CTRL bit 31 is stored, reads back and drives the hub enable output.
- R9: The interrupt is the OR of status bits ANDed with the enable bits in IEN (offset 0x08, same bit positions). The DMA requests ignore IEN.
- R10: Host writes to TXD (offset 0x10) are popped by the audio side in write order, with the head sample presented on the transmit sample output. A write into a full transmit queue (128 entries) is dropped.
- R11: LVL reports receive occupancy in bits [15:0] and transmit occupancy in bits [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_push | input | 1 | Audio side pushes one receive sample |
| rx_sample | input | 32 | Sample to push |
| tx_pop | input | 1 | Audio side takes one transmit sample |
| tx_sample | output | 32 | Head of the transmit queue |
| dma_rx_req | output | 1 | Receive threshold condition |
| dma_tx_req | output | 1 | Transmit threshold condition |
| irq | output | 1 | Masked OR of pending flags |
| hub_en | output | 1 | Stored hub enable bit |

## Verification
The bench builds the block with its default parameters: 64 receive entries, 128 transmit entries, and trigger fields that reset to 15 and 64. At these sizes a full-depth overrun and a transmit-full drop each need only about 130 accesses, so both are reached without shrinking the queues. The reset thresholds are checked as they are. The transmit field is then set to 4 so that the condition can be made to fall and rise again from the bus. Each flag is driven through its rise, its clear by a one-write while the condition still holds, and its self-clear.

// File: rtl/afq_pkg.sv
package afq_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 5;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RXD  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_TXD  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_LVL  = 5'h14;

    // Control word layout
    localparam int CTRL_HUB_BIT  = 31;
    localparam int CTRL_TXFL_BIT = 25;
    localparam int CTRL_RXFL_BIT = 24;
    localparam int TXTRIG_LSB    = 12;
    localparam int RXTRIG_LSB    = 4;

    // Pending / enable bit positions
    localparam int PB_RXAV = 0;
    localparam int PB_OVR  = 1;
    localparam int PB_TXRQ = 2;
    localparam int PB_N    = 3;

    typedef enum logic [2:0] {
        RG_CTRL, RG_STAT, RG_IEN, RG_RXD, RG_TXD, RG_LVL, RG_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  wdata;
    } bus_req_t;

    typedef struct packed {
        logic full;
        logic empty;
        logic drop;
    } fifo_flags_t;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        reg_sel_e r;
        case (a)
            OFS_CTRL: r = RG_CTRL;
            OFS_STAT: r = RG_STAT;
            OFS_IEN:  r = RG_IEN;
            OFS_RXD:  r = RG_RXD;
            OFS_TXD:  r = RG_TXD;
            OFS_LVL:  r = RG_LVL;
            default:  r = RG_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] lvl_word(logic [15:0] rxc, logic [15:0] txc);
        return {txc, rxc};
    endfunction

endpackage

// File: rtl/afq_fifo.sv
module afq_fifo
    import afq_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output fifo_flags_t       flags
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign flags.full  = (count == CNT_W'(DEPTH));
    assign flags.empty = (count == '0);
    assign flags.drop  = push & flags.full & ~flush;

    assign do_push = push & ~flags.full & ~flush;
    assign do_pop  = pop & ~flags.empty & ~flush;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R5 / R10: occupancy never passes the depth
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R5 / R10: a dropped push leaves the queue still full
    p_drop_keeps_full_r5: assert property (@(posedge clk) disable iff (rst)
        (push && flags.full && !pop && !flush) |=> flags.full);

    p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (count - $past(count) <= CNT_W'(1)) || ($past(count) - count <= CNT_W'(1)));

endmodule

// File: rtl/afq_pend_flag.sv
module afq_pend_flag #(
    parameter bit STICKY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic clr,
    output logic flag
);

    generate
        if (STICKY) begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst) flag <= 1'b0;
                else     flag <= cond | (flag & ~clr);
            end

            p_sticky_hold_r5: assert property (@(posedge clk) disable iff (rst)
                (flag && !clr) |=> flag);
            p_sticky_set_r5: assert property (@(posedge clk) disable iff (rst)
                cond |=> flag);
        end else begin : g_level
            logic cond_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cond_q <= 1'b0;
                    flag   <= 1'b0;
                end else begin
                    cond_q <= cond;
                    flag   <= (flag | (cond & ~cond_q)) & cond & ~clr;
                end
            end

            // R4 / R6: flag drops once the condition fails
            p_auto_clear_r4: assert property (@(posedge clk) disable iff (rst)
                !cond |=> !flag);
            p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
                clr |=> !flag);
        end
    endgenerate

endmodule

// File: rtl/afq_ctrl.sv
module afq_ctrl
    import afq_pkg::*;
#(
    parameter int RX_DEPTH    = 64,
    parameter int TX_DEPTH    = 128,
    parameter int RX_TRIG_W   = 6,
    parameter int TX_TRIG_W   = 7,
    parameter int RX_TRIG_RST = 15,
    parameter int TX_TRIG_RST = 64,
    localparam int RXC_W = $clog2(RX_DEPTH) + 1,
    localparam int TXC_W = $clog2(TX_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rx_push,
    input  logic [BUS_W-1:0]  rx_sample,
    input  logic              tx_pop,
    output logic [BUS_W-1:0]  tx_sample,
    output logic              dma_rx_req,
    output logic              dma_tx_req,
    output logic              irq,
    output logic              hub_en
);

    bus_req_t    req;
    reg_sel_e    rsel;
    logic        wr_ctrl, wr_stat, wr_ien, wr_txd, rd_rxd;

    logic [RX_TRIG_W-1:0] rx_trig_q;
    logic [TX_TRIG_W-1:0] tx_trig_q;
    logic                 hub_q;
    logic [PB_N-1:0]      ien_q;
    logic [PB_N-1:0]      pend;
    logic [PB_N-1:0]      stat_clr;
    logic                 rx_flush, tx_flush;

    logic [RXC_W-1:0]     rx_cnt;
    logic [TXC_W-1:0]     tx_cnt;
    logic [BUS_W-1:0]     rx_head;
    fifo_flags_t          rx_fl, tx_fl;
    logic                 rx_cond, tx_cond;
    logic [BUS_W-1:0]     ctrl_rd;

    assign req  = '{sel: bus_sel, we: bus_we, addr: bus_addr, wdata: bus_wdata};
    assign rsel = decode_addr(req.addr);

    assign wr_ctrl = req.sel & req.we & (rsel == RG_CTRL);
    assign wr_stat = req.sel & req.we & (rsel == RG_STAT);
    assign wr_ien  = req.sel & req.we & (rsel == RG_IEN);
    assign wr_txd  = req.sel & req.we & (rsel == RG_TXD);
    assign rd_rxd  = req.sel & ~req.we & (rsel == RG_RXD);

    assign rx_flush = wr_ctrl & req.wdata[CTRL_RXFL_BIT];
    assign tx_flush = wr_ctrl & req.wdata[CTRL_TXFL_BIT];
    assign stat_clr = wr_stat ? req.wdata[PB_N-1:0] : '0;

    // Control and enable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_trig_q <= RX_TRIG_W'(RX_TRIG_RST);
            tx_trig_q <= TX_TRIG_W'(TX_TRIG_RST);
            hub_q     <= 1'b0;
            ien_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                rx_trig_q <= req.wdata[RXTRIG_LSB +: RX_TRIG_W];
                tx_trig_q <= req.wdata[TXTRIG_LSB +: TX_TRIG_W];
                hub_q     <= req.wdata[CTRL_HUB_BIT];
            end
            if (wr_ien) ien_q <= req.wdata[PB_N-1:0];
        end
    end

    // Sample queues
    afq_fifo #(.DEPTH(RX_DEPTH), .DATA_W(BUS_W)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_data (rx_sample),
        .pop       (rd_rxd),
        .head      (rx_head),
        .count     (rx_cnt),
        .flags     (rx_fl)
    );

    afq_fifo #(.DEPTH(TX_DEPTH), .DATA_W(BUS_W)) u_tx_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .push      (wr_txd),
        .push_data (req.wdata),
        .pop       (tx_pop),
        .head      (tx_sample),
        .count     (tx_cnt),
        .flags     (tx_fl)
    );

    // Threshold conditions
    assign rx_cond = (16'(rx_cnt) >= (16'(rx_trig_q) + 16'd1));
    assign tx_cond = (16'(tx_cnt) <= 16'(tx_trig_q));

    assign dma_rx_req = rx_cond;
    assign dma_tx_req = tx_cond;

    // Pending flags
    afq_pend_flag #(.STICKY(1'b0)) u_pf_rxav (
        .clk(clk), .rst(rst), .cond(rx_cond), .clr(stat_clr[PB_RXAV]), .flag(pend[PB_RXAV])
    );
    afq_pend_flag #(.STICKY(1'b1)) u_pf_ovr (
        .clk(clk), .rst(rst), .cond(rx_fl.drop), .clr(stat_clr[PB_OVR]), .flag(pend[PB_OVR])
    );
    afq_pend_flag #(.STICKY(1'b0)) u_pf_txrq (
        .clk(clk), .rst(rst), .cond(tx_cond), .clr(stat_clr[PB_TXRQ]), .flag(pend[PB_TXRQ])
    );

    assign irq    = |(pend & ien_q);
    assign hub_en = hub_q;

    // Read mux
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CTRL_HUB_BIT]                 = hub_q;
        ctrl_rd[TXTRIG_LSB +: TX_TRIG_W]      = tx_trig_q;
        ctrl_rd[RXTRIG_LSB +: RX_TRIG_W]      = rx_trig_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            RG_CTRL: bus_rdata = ctrl_rd;
            RG_STAT: bus_rdata = BUS_W'(pend);
            RG_IEN:  bus_rdata = BUS_W'(ien_q);
            RG_RXD:  bus_rdata = rx_fl.empty ? '0 : rx_head;
            RG_LVL:  bus_rdata = lvl_word(16'(rx_cnt), 16'(tx_cnt));
            default: bus_rdata = '0;
        endcase
    end

    // R7: flush leaves the queue empty on the next cycle
    p_flush_rx_r7: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (rx_cnt == '0));
    p_flush_tx_r7: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (tx_cnt == '0));
    // R9: nothing enabled, no interrupt
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);
    // R3: an empty receive queue never requests
    p_rx_empty_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt == '0) |-> !dma_rx_req);

endmodule

// File: tb/afq_ctrl_tb_top.sv
`timescale 1ns/1ps
module afq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        rx_push = 1'b0, tx_pop = 1'b0;
    logic [31:0] rx_sample = '0, tx_sample;
    logic        dma_rx_req, dma_tx_req, irq, hub_en;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_IEN = 5'h08,
                           A_RXD = 5'h0C, A_TXD = 5'h10, A_LVL = 5'h14;
    localparam logic [31:0] CTRL_DEF = 32'h000400F0;
    localparam logic [31:0] CTRL_TX4 = (32'd4 << 12) | (32'd15 << 4);

    always #2 clk = ~clk;

    afq_ctrl dut_i (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_push(rx_push), .rx_sample(rx_sample),
        .tx_pop(tx_pop), .tx_sample(tx_sample),
        .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
        .irq(irq), .hub_en(hub_en)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bwr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic brd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic apush(logic [31:0] d);
        @(negedge clk);
        rx_push = 1; rx_sample = d;
        @(posedge clk); #1;
        rx_push = 0;
    endtask

    task automatic apop(output logic [31:0] d);
        @(negedge clk);
        tx_pop = 1;
        #1 d = tx_sample;
        @(posedge clk); #1;
        tx_pop = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        brd(A_CTRL, d); chk("R1 ctrl", d, CTRL_DEF);
        brd(A_LVL, d);  chk("R1 lvl", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 hub", {31'b0, hub_en}, 0);
        chk("R6 tx req at reset", {31'b0, dma_tx_req}, 1);
        chk("R3 rx req at reset", {31'b0, dma_rx_req}, 0);
        brd(A_RXD, d);  chk("R2 empty read", d, 0);
    endtask

    task automatic t_hub();
        logic [31:0] d;
        bwr(A_CTRL, CTRL_DEF | 32'h8000_0000);
        brd(A_CTRL, d); chk("R8 readback", d, CTRL_DEF | 32'h8000_0000);
        chk("R8 pin", {31'b0, hub_en}, 1);
        bwr(A_CTRL, CTRL_DEF);
        chk("R8 pin off", {31'b0, hub_en}, 0);
    endtask

    task automatic t_rx_order();
        logic [31:0] d;
        apush(32'hA000_0001); apush(32'hB000_0001);
        apush(32'hA000_0002); apush(32'hB000_0002);
        brd(A_LVL, d); chk("R11 rx level", d, 4);
        brd(A_RXD, d); chk("R2 left0", d, 32'hA000_0001);
        brd(A_RXD, d); chk("R2 right0", d, 32'hB000_0001);
        brd(A_RXD, d); chk("R2 left1", d, 32'hA000_0002);
        brd(A_RXD, d); chk("R2 right1", d, 32'hB000_0002);
        brd(A_LVL, d); chk("R11 rx drained", d, 0);
    endtask

    task automatic t_rx_thresh();
        logic [31:0] d;
        for (int i = 0; i < 15; i++) apush(32'h100 + i);
        chk("R3 at 15", {31'b0, dma_rx_req}, 0);
        apush(32'h10F);
        chk("R3 at 16", {31'b0, dma_rx_req}, 1);
        idle(2);
        brd(A_STAT, d); chk("R4 set", d & 1, 1);
        bwr(A_STAT, 32'h1);
        idle(2);
        brd(A_STAT, d); chk("R4 w1c stays clear", d & 1, 0);
        chk("R3 still high", {31'b0, dma_rx_req}, 1);
        brd(A_RXD, d);
        chk("R3 back at 15", {31'b0, dma_rx_req}, 0);
        apush(32'h110);
        idle(2);
        brd(A_STAT, d); chk("R4 set again", d & 1, 1);
        brd(A_RXD, d);
        idle(2);
        brd(A_STAT, d); chk("R4 self clear", d & 1, 0);
        bwr(A_CTRL, CTRL_DEF | (32'd1 << 24));
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        for (int i = 0; i < 64; i++) apush(32'h1000 + i);
        apush(32'hDEAD_BEEF);
        brd(A_LVL, d); chk("R5 level capped", d, 64);
        idle(2);
        brd(A_STAT, d); chk("R5 overrun set", (d >> 1) & 1, 1);
        begin
            int bad = 0;
            for (int i = 0; i < 64; i++) begin
                brd(A_RXD, d);
                if (d !== 32'h1000 + i) bad++;
            end
            chk("R5 data intact", bad, 0);
        end
        idle(2);
        brd(A_STAT, d); chk("R5 sticky", (d >> 1) & 1, 1);
        bwr(A_STAT, 32'h2);
        idle(1);
        brd(A_STAT, d); chk("R5 w1c", (d >> 1) & 1, 0);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        bwr(A_CTRL, CTRL_TX4);
        chk("R6 empty vs 4", {31'b0, dma_tx_req}, 1);
        for (int i = 0; i < 5; i++) bwr(A_TXD, 32'h2000 + i);
        chk("R6 five vs 4", {31'b0, dma_tx_req}, 0);
        idle(2);
        brd(A_STAT, d); chk("R6 self clear", (d >> 2) & 1, 0);
        apop(d); chk("R10 head", d, 32'h2000);
        chk("R6 four vs 4", {31'b0, dma_tx_req}, 1);
        idle(2);
        brd(A_STAT, d); chk("R6 set", (d >> 2) & 1, 1);
        bwr(A_STAT, 32'h4);
        idle(2);
        brd(A_STAT, d); chk("R6 w1c", (d >> 2) & 1, 0);
        bwr(A_CTRL, CTRL_TX4 | (32'd1 << 25));
        for (int i = 0; i < 129; i++) bwr(A_TXD, 32'h3000 + i);
        brd(A_LVL, d); chk("R10 tx level capped", d, 128 << 16);
        begin
            int bad = 0;
            for (int i = 0; i < 128; i++) begin
                apop(d);
                if (d !== 32'h3000 + i) bad++;
            end
            chk("R10 order", bad, 0);
        end
        brd(A_LVL, d); chk("R10 drained", d, 0);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        for (int i = 0; i < 3; i++) begin
            apush(32'h40 + i);
            bwr(A_TXD, 32'h50 + i);
        end
        bwr(A_CTRL, CTRL_DEF | (32'd1 << 24));
        brd(A_LVL, d); chk("R7 rx flushed", d, 3 << 16);
        brd(A_CTRL, d); chk("R7 bits read 0", d, CTRL_DEF);
        bwr(A_CTRL, CTRL_DEF | (32'd1 << 25));
        brd(A_LVL, d); chk("R7 tx flushed", d, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        for (int i = 0; i < 65; i++) apush(32'h60 + i);
        idle(2);
        chk("R9 masked", {31'b0, irq}, 0);
        chk("R9 dma ignores mask", {31'b0, dma_rx_req}, 1);
        bwr(A_IEN, 32'h2);
        chk("R9 ovr enabled", {31'b0, irq}, 1);
        bwr(A_STAT, 32'h2);
        idle(1);
        chk("R9 ovr cleared", {31'b0, irq}, 0);
        bwr(A_IEN, 32'h1);
        chk("R9 avail enabled", {31'b0, irq}, 1);
        bwr(A_IEN, 32'h0);
        bwr(A_CTRL, CTRL_DEF | (32'd1 << 24));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_hub();
        t_rx_order();
        t_rx_thresh();
        t_overrun();
        t_tx();
        t_flush();
        t_irq();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule